// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked user port and an external asynchronous static RAM with two chip selects (one active low, one active high), active-low write and output strobes, and two active-low byte-lane enables. The user side offers one single-beat read or write at a time through a valid/ready handshake. Each request carries a 21-bit address, 16-bit write data, a 2-bit lane mask and a mode bit that picks 16-bit word access or 8-bit byte access.

The controller registers the request. It then runs the RAM strobes through intervals counted in clock cycles, and each interval length is a parameter. Reads are sampled on the clock edge that ends the access window and are returned with a one-cycle valid pulse. After every read a turnaround gap passes before the controller may drive the shared data bus again. A check at elaboration rejects interval values that are too short for the configured clock period and RAM timing.

In byte mode the lowest request address bit goes out on a separate device address line. Byte data then travels only on the low eight data lines.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller holds `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lane_n`=2'b11, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=0. Within a few cycles after release, `req_ready` rises.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the access and any turnaround have finished.
- R3: A read keeps the RAM selected with `mem_we_n`=1 and `mem_oe_n`=0 for exactly `RD_CYC` cycles after acceptance. The data bus is sampled at the edge that ends this window, and `rsp_valid` is high for exactly one cycle right after that edge, with the data on `rsp_rdata`.
- R4: A write keeps the RAM selected with `mem_dq_oe`=1 for `WR_SETUP_CYC`+`WR_PULSE_CYC`+`WR_RECOV_CYC` cycles. `mem_we_n` is high for the first `WR_SETUP_CYC` cycles, low for the next `WR_PULSE_CYC` cycles and high for the last `WR_RECOV_CYC` cycles. The RAM is then deselected and the bus is released.
- R5: `mem_addr` and `mem_addr_lsb` change only while `mem_we_n` is high both before and after the change. They are stable from acceptance to the end of the access.
- R6: `mem_we_n` and `mem_oe_n` are never low together, and `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: After a read, `mem_oe_n` rises at the edge that ends the read window. For the next `TURN_CYC` cycles `mem_dq_oe` stays low and `req_ready` stays low.
- R8: Word mode (`req_word`=1) drives `mem_word`=1, `mem_addr`=request address bits 19..0 (bit 20 is ignored) and `mem_addr_lsb`=0. It drives `mem_lane_n`[0]=!mask[0] and `mem_lane_n`[1]=!mask[1], and a mask of 2'b00 enables both lanes. Write data goes out unchanged on `mem_dq_out`, with bits 7..0 on the lower lane.
- R9: On a word-mode read, a lane whose mask bit is off returns 8'h00 in `rsp_rdata`, whatever the bus carries.
- R10: Byte mode (`req_word`=0) drives `mem_word`=0, `mem_addr`=request address bits 20..1, `mem_addr_lsb`=request address bit 0 and `mem_lane_n`=2'b10, and ignores the mask. A write drives data bits 7..0 on `mem_dq_out`[7:0] and zero on `mem_dq_out`[15:8]. A read returns {8'h00, bus bits 7..0}.
- R11: While idle with no request, the RAM stays deselected (`mem_cs_n`=1, `mem_cs`=0) with both strobes high and the bus driver off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| req_addr | input | 21 | Word address (word mode) or byte address (byte mode) |
| req_mask | input | 2 | Lane mask in word mode, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 20 | RAM address |
| mem_addr_lsb | output | 1 | RAM byte-select address bit (byte mode) |
| mem_word | output | 1 | RAM organisation select, 1 = word |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write strobe |
| mem_oe_n | output | 1 | Output enable |
| mem_lane_n | output | 2 | Active-low lane enables, bit 0 = low byte |
| mem_dq_out | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
The bench connects a behavioural RAM whose bytes alias between word and byte addressing. Word writes with full, single-lane and empty masks are followed by reads with different masks, so lane steering can be told apart from lane masking. Byte writes and reads at odd and even byte addresses, checked again through word reads, show whether the low address bit and the lane choice land on the right byte. Reads placed directly before writes, and writes placed back to back, expose turnaround and strobe-window errors, because every access is timed cycle by cycle against the configured counts.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV
  } ctrl_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q = sync_q[1];

endmodule

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter  int ADDR_W = 21,
  parameter  int DATA_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int DEV_AW = ADDR_W - 1
) (
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DEV_AW-1:0] dev_addr,
  output logic              dev_lsb,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] dq_wr,
  input  logic [LANES-1:0]  rd_lane_n,
  input  logic [DATA_W-1:0] dq_rd,
  output logic [DATA_W-1:0] rdata
);

  logic [LANES-1:0] mask_eff;

  assign mask_eff = (mask == '0) ? '1 : mask;
  assign dev_addr = word_mode ? addr[DEV_AW-1:0] : addr[ADDR_W-1:1];
  assign dev_lsb  = word_mode ? 1'b0 : addr[0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign lane_n[g]        = word_mode ? ~mask_eff[g] : 1'b0;
      assign dq_wr[g*8 +: 8]  = wdata[g*8 +: 8];
    end else begin : g_high
      assign lane_n[g]        = word_mode ? ~mask_eff[g] : 1'b1;
      assign dq_wr[g*8 +: 8]  = word_mode ? wdata[g*8 +: 8] : 8'h00;
    end
    assign rdata[g*8 +: 8] = rd_lane_n[g] ? 8'h00 : dq_rd[g*8 +: 8];
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter  int ADDR_W       = 21,
  parameter  int DATA_W       = 16,
  parameter  int CLK_NS       = 20,
  parameter  int T_ACCESS_NS  = 55,
  parameter  int T_RCYC_NS    = 55,
  parameter  int T_WCYC_NS    = 55,
  parameter  int T_WPULSE_NS  = 30,
  parameter  int T_DSETUP_NS  = 25,
  parameter  int T_OFF_NS     = 25,
  parameter  int RD_CYC       = 3,
  parameter  int WR_SETUP_CYC = 1,
  parameter  int WR_PULSE_CYC = 2,
  parameter  int WR_RECOV_CYC = 1,
  parameter  int TURN_CYC     = 2,
  localparam int LANES        = DATA_W / 8,
  localparam int DEV_AW       = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DEV_AW-1:0] mem_addr,
  output logic              mem_addr_lsb,
  output logic              mem_word,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  import sram_ctrl_pkg::*;

  localparam int MAX_CYC = int'(max_of(max_of(max_of(RD_CYC, WR_SETUP_CYC),
                                   max_of(WR_PULSE_CYC, WR_RECOV_CYC)), TURN_CYC));
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WS   = CNT_W'(WR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(WR_RECOV_CYC - 1);

  localparam bit PARAMS_OK =
    (RD_CYC >= 1) && (WR_SETUP_CYC >= 1) && (WR_PULSE_CYC >= 1) &&
    (WR_RECOV_CYC >= 1) && (TURN_CYC >= 1) && (DATA_W == 8 * LANES) &&
    (RD_CYC * CLK_NS >= T_ACCESS_NS) &&
    ((RD_CYC + TURN_CYC) * CLK_NS >= T_RCYC_NS) &&
    ((WR_SETUP_CYC + WR_PULSE_CYC + WR_RECOV_CYC) * CLK_NS >= T_WCYC_NS) &&
    (WR_PULSE_CYC * CLK_NS >= T_WPULSE_NS) &&
    ((WR_SETUP_CYC + WR_PULSE_CYC) * CLK_NS >= T_DSETUP_NS) &&
    (TURN_CYC * CLK_NS >= T_OFF_NS);

  initial begin
    AST_PARAMS_OK: assert (PARAMS_OK)
      else $error("sram_async_ctrl: interval parameters too short for clock period");
  end

  logic rst_q;

  sram_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // state and strobe registers
  ctrl_state_e       st_q, st_d;
  logic              sel_q, sel_d;
  logic              we_n_q, we_n_d;
  logic              oe_n_q, oe_n_d;
  logic              dq_oe_q, dq_oe_d;
  logic              rsp_q, rsp_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_done;
  logic              accept;
  logic              capture;

  // request-side registers (loaded on accept)
  logic [DEV_AW-1:0] addr_q;
  logic              lsb_q;
  logic              word_q;
  logic [LANES-1:0]  lane_n_q;
  logic [DATA_W-1:0] dq_q;
  logic [DATA_W-1:0] rdata_q;

  logic [DEV_AW-1:0] map_addr;
  logic              map_lsb;
  logic [LANES-1:0]  map_lane_n;
  logic [DATA_W-1:0] map_dq;
  logic [DATA_W-1:0] map_rdata;

  sram_lane_map #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_map (
    .word_mode (req_word),
    .addr      (req_addr),
    .mask      (req_mask),
    .wdata     (req_wdata),
    .dev_addr  (map_addr),
    .dev_lsb   (map_lsb),
    .lane_n    (map_lane_n),
    .dq_wr     (map_dq),
    .rd_lane_n (lane_n_q),
    .dq_rd     (mem_dq_in),
    .rdata     (map_rdata)
  );

  sram_interval_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign req_ready = rst_q && (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    we_n_d   = we_n_q;
    oe_n_d   = oe_n_q;
    dq_oe_d  = dq_oe_q;
    rsp_d    = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          sel_d    = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            st_d    = ST_WSETUP;
            dq_oe_d = 1'b1;
            tmr_val = LD_WS;
          end else begin
            st_d    = ST_READ;
            oe_n_d  = 1'b0;
            tmr_val = LD_RD;
          end
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          capture  = 1'b1;
          rsp_d    = 1'b1;
          sel_d    = 1'b0;
          oe_n_d   = 1'b1;
          st_d     = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = LD_TURN;
        end
      end
      ST_TURN: begin
        if (tmr_done) begin
          st_d = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        if (tmr_done) begin
          we_n_d   = 1'b0;
          st_d     = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_WP;
        end
      end
      ST_WPULSE: begin
        if (tmr_done) begin
          we_n_d   = 1'b1;
          st_d     = ST_WRECOV;
          tmr_load = 1'b1;
          tmr_val  = LD_WR;
        end
      end
      ST_WRECOV: begin
        if (tmr_done) begin
          sel_d   = 1'b0;
          dq_oe_d = 1'b0;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q    <= ST_IDLE;
      sel_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
      rsp_q   <= rsp_d;
    end
  end

  // request registers, enabled on accept
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      addr_q   <= '0;
      lsb_q    <= 1'b0;
      word_q   <= 1'b1;
      lane_n_q <= '1;
      dq_q     <= '0;
    end else if (accept) begin
      addr_q   <= map_addr;
      lsb_q    <= map_lsb;
      word_q   <= req_word;
      lane_n_q <= map_lane_n;
      dq_q     <= map_dq;
    end
  end

  // read data register, enabled on capture
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= map_rdata;
    end
  end

  assign rsp_valid    = rsp_q;
  assign rsp_rdata    = rdata_q;
  assign mem_addr     = addr_q;
  assign mem_addr_lsb = lsb_q;
  assign mem_word     = word_q;
  assign mem_cs_n     = ~sel_q;
  assign mem_cs       = sel_q;
  assign mem_we_n     = we_n_q;
  assign mem_oe_n     = oe_n_q;
  assign mem_lane_n   = lane_n_q | {LANES{~sel_q}};
  assign mem_dq_out   = dq_q;
  assign mem_dq_oe    = dq_oe_q;

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    !mem_we_n |-> mem_oe_n); // R6

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_q)
    mem_dq_oe |-> mem_oe_n); // R6

  AST_ADDR_HOLD_WE: assert property (@(posedge clk) disable iff (!rst_q)
    (!mem_we_n || !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_addr_lsb))); // R5

  AST_LANE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_q)
    mem_cs |-> !(&mem_lane_n)); // R8

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid |=> !rsp_valid); // R3

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_q)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe)); // R11

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid |-> ($rose(mem_oe_n) && !req_ready)); // R7

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  localparam int RD   = 3;
  localparam int WS   = 1;
  localparam int WP   = 2;
  localparam int WR   = 1;
  localparam int TURN = 2;
  localparam int WT   = WS + WP + WR;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_word;
  logic [20:0] req_addr;
  logic [1:0]  req_mask;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_addr_lsb, mem_word, mem_cs_n, mem_cs, mem_we_n, mem_oe_n;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0]  ram_b [0:511];
  logic [7:0]  ref_b [0:511];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  sram_async_ctrl #(
    .RD_CYC (RD), .WR_SETUP_CYC (WS), .WR_PULSE_CYC (WP),
    .WR_RECOV_CYC (WR), .TURN_CYC (TURN)
  ) u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_word (req_word), .req_addr (req_addr), .req_mask (req_mask),
    .req_wdata (req_wdata), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_addr (mem_addr), .mem_addr_lsb (mem_addr_lsb), .mem_word (mem_word),
    .mem_cs_n (mem_cs_n), .mem_cs (mem_cs), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_lane_n (mem_lane_n), .mem_dq_out (mem_dq_out),
    .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural RAM: bytes alias between word and byte addressing
  wire       sel = (mem_cs_n === 1'b0) && (mem_cs === 1'b1);
  wire [8:0] lo_i = {mem_addr[7:0], 1'b0};
  wire [8:0] hi_i = {mem_addr[7:0], 1'b1};
  wire [8:0] by_i = {mem_addr[7:0], mem_addr_lsb};

  always_comb begin
    mem_dq_in = 16'hDEAD;
    if (sel && mem_oe_n === 1'b0 && mem_we_n === 1'b1) begin
      if (mem_word) begin
        mem_dq_in[7:0]  = mem_lane_n[0] ? 8'h5A : ram_b[lo_i];
        mem_dq_in[15:8] = mem_lane_n[1] ? 8'h5A : ram_b[hi_i];
      end else begin
        mem_dq_in = {8'hA5, ram_b[by_i]};
      end
    end
  end

  always @(posedge clk) begin
    if (sel && mem_we_n === 1'b0) begin
      if (mem_word) begin
        if (!mem_lane_n[0]) ram_b[lo_i] <= mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
        if (!mem_lane_n[1]) ram_b[hi_i] <= mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
      end else begin
        ram_b[by_i] <= mem_dq_oe ? mem_dq_out[7:0] : 8'hEE;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected rsp_valid", 32'(rsp_rdata), 32'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata === e, t, "read data", 32'(rsp_rdata), 32'(e));
      end
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit word);
    logic [1:0]  me;
    logic [19:0] ea;
    int first_low, n_low;
    bit ok_sel, ok_hold, ok_excl, ok_rdy;
    me = (m == 2'b00) ? 2'b11 : m;
    ea = word ? a[19:0] : a[20:1];
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_word = word;
    req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    first_low = 0; n_low = 0;
    ok_sel = 1; ok_hold = 1; ok_excl = 1; ok_rdy = 1;
    for (int i = 1; i <= WT + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", 32'(req_ready), 32'h0);
        chk(mem_addr == ea, word ? "R8" : "R10", "write address", 32'(mem_addr), 32'(ea));
        chk(mem_addr_lsb == (word ? 1'b0 : a[0]), word ? "R8" : "R10", "address lsb",
            32'(mem_addr_lsb), 32'(word ? 1'b0 : a[0]));
        chk(mem_word == word, word ? "R8" : "R10", "word select", 32'(mem_word), 32'(word));
        chk(mem_lane_n == (word ? ~me : 2'b10), word ? "R8" : "R10", "lane enables",
            32'(mem_lane_n), 32'(word ? ~me : 2'b10));
        chk(mem_dq_out == (word ? d : {8'h00, d[7:0]}), word ? "R8" : "R10", "write data",
            32'(mem_dq_out), 32'(word ? d : {8'h00, d[7:0]}));
      end
      if (i <= WT) begin
        if (!(mem_cs && !mem_cs_n && mem_dq_oe)) ok_sel = 0;
        if (mem_addr != ea) ok_hold = 0;
        if (req_ready) ok_rdy = 0;
        if (!mem_we_n) begin
          if (first_low == 0) first_low = i;
          n_low++;
        end
      end
      if (!mem_we_n && !mem_oe_n) ok_excl = 0;
      if (mem_dq_oe && !mem_oe_n) ok_excl = 0;
    end
    chk(ok_sel, "R4", "selected and driving through write", 32'(ok_sel), 32'h1);
    chk(first_low == WS + 1, "R4", "strobe start cycle", 32'(first_low), 32'(WS + 1));
    chk(n_low == WP, "R4", "strobe width", 32'(n_low), 32'(WP));
    chk(mem_cs_n && !mem_cs && !mem_dq_oe && mem_we_n, "R4", "released after recovery",
        32'({mem_cs_n, mem_cs, mem_dq_oe, mem_we_n}), 32'b1001);
    chk(ok_hold && mem_addr == ea, "R5", "address held across write", 32'(mem_addr), 32'(ea));
    chk(ok_excl, "R6", "strobe exclusion", 32'(ok_excl), 32'h1);
    chk(ok_rdy && req_ready, "R2", "ready low during write, high after", 32'(req_ready), 32'h1);
    if (word) begin
      if (me[0]) ref_b[{a[7:0], 1'b0}] = d[7:0];
      if (me[1]) ref_b[{a[7:0], 1'b1}] = d[15:8];
    end else begin
      ref_b[a[8:0]] = d[7:0];
    end
  endtask

  task automatic do_read(input logic [20:0] a, input logic [1:0] m,
                         input bit word, input string tag);
    logic [1:0]  me;
    logic [15:0] e;
    bit ok_rd, ok_turn, ok_excl;
    me = (m == 2'b00) ? 2'b11 : m;
    if (word) e = {me[1] ? ref_b[{a[7:0], 1'b1}] : 8'h00, me[0] ? ref_b[{a[7:0], 1'b0}] : 8'h00};
    else      e = {8'h00, ref_b[a[8:0]]};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_word = word;
    req_addr = a; req_mask = m; req_wdata = 16'hFFFF;
    @(posedge clk);
    ok_rd = 1; ok_turn = 1; ok_excl = 1;
    for (int i = 1; i <= RD + TURN + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after read accept", 32'(req_ready), 32'h0);
      end
      if (i <= RD) begin
        if (!(mem_cs && !mem_cs_n && !mem_oe_n && mem_we_n && !rsp_valid)) ok_rd = 0;
      end else if (i <= RD + TURN) begin
        if (req_ready || mem_dq_oe || !mem_oe_n) ok_turn = 0;
        if (i == RD + 1)
          chk(rsp_valid == 1'b1, "R3", "valid after read window", 32'(rsp_valid), 32'h1);
        if (i == RD + 2)
          chk(rsp_valid == 1'b0, "R3", "valid one cycle", 32'(rsp_valid), 32'h0);
      end
      if (mem_dq_oe && !mem_oe_n) ok_excl = 0;
    end
    chk(ok_rd, "R3", "read strobes for read window", 32'(ok_rd), 32'h1);
    chk(ok_turn, "R7", "turnaround gap", 32'(ok_turn), 32'h1);
    chk(ok_excl, "R6", "no drive during read", 32'(ok_excl), 32'h1);
    chk(req_ready == 1'b1, "R7", "ready after turnaround", 32'(req_ready), 32'h1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2", "watchdog expired", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      ram_b[i] = 8'(i) ^ 8'h3C;
      ref_b[i] = 8'(i) ^ 8'h3C;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b1;
    req_addr = '0; req_mask = 2'b11; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rsp_valid, req_ready}
        == 9'b101111000, "R1", "reset outputs",
        32'({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rsp_valid, req_ready}),
        32'b101111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset release", 32'(req_ready), 32'h1);
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, "R11", "idle deselected",
        32'({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}), 32'b10110);

    do_write(21'h000005, 16'h1234, 2'b11, 1'b1);
    do_read (21'h000005, 2'b11, 1'b1, "R3");
    do_write(21'h000005, 16'hABCD, 2'b01, 1'b1);
    do_read (21'h000005, 2'b10, 1'b1, "R9");
    do_read (21'h000005, 2'b01, 1'b1, "R9");
    do_read (21'h000005, 2'b00, 1'b1, "R8");
    do_write(21'h100007, 16'h5AA5, 2'b00, 1'b1);
    do_read (21'h000007, 2'b11, 1'b1, "R8");
    do_write(21'h00000B, 16'h77EE, 2'b01, 1'b0);
    do_read (21'h00000A, 2'b00, 1'b0, "R10");
    do_read (21'h00000B, 2'b11, 1'b0, "R10");
    do_read (21'h000005, 2'b11, 1'b1, "R10");
    do_write(21'h000010, 16'h0F0F, 2'b10, 1'b1);
    do_write(21'h000011, 16'hC3C3, 2'b11, 1'b1);
    do_read (21'h000010, 2'b11, 1'b1, "R8");
    do_read (21'h000011, 2'b11, 1'b1, "R3");
    do_write(21'h000020, 16'h9999, 2'b00, 1'b0);
    do_read (21'h000010, 2'b11, 1'b1, "R10");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all reads answered", 32'(exp_q.size()), 32'h0);
    chk(mem_cs_n && !mem_dq_oe && mem_we_n && mem_oe_n, "R11", "idle after traffic",
        32'({mem_cs_n, mem_dq_oe, mem_we_n, mem_oe_n}), 32'b1011);
    done = 1;
    finish_run();
  end

endmodule